// File: doc/BRIEF.md
# Edge-Cleared Capture/Compare Timer

This block is a 16-bit up-counter that advances on a count-clock enable and can be forced back to zero by an edge on an external trigger pin. It is meant for measuring pulse periods and widths, or for producing events at chosen points within a period that an outside signal restarts. Two 16-bit registers back the counter. Each either holds a compare value that raises an interrupt pulse when the counter reaches it, or takes a snapshot of the counter when an edge arrives.

Both external pins first pass through a two-flop synchronizer and then through an edge detector. Each pin has its own polarity selector. In capture mode, a trigger edge stores the running count in the second register and clears the counter in the same cycle. The first register stores the count on an edge of the second pin, or on the opposite phase of the trigger pin. A toggle output inverts on every compare match while it is enabled.

Software writes the registers and reads either register or the live count through a simple select-based register interface. All mode and polarity fields are plain inputs.

Top module: `edge_clear_timer`

## Requirements
- R1: When `mode` is not binary 10, the counter is held at 0000h, both interrupt outputs stay low, and `toggleOut` is driven low one cycle later.
- R2: With `mode` = 10, the counter increases by one on every clock where `countEn` is high. It rolls from FFFFh to 0000h and keeps counting.
- R3: A valid trigger edge loads 0000h into the counter. If the same cycle also has a count enable, the clear wins. The edge takes effect on the third rising clock edge after the pin changes, because of two synchronizer stages and one edge-detect stage.
- R4: Each pin's edge select works as follows: 00 gives no edge, 01 gives rising, 10 gives falling, and 11 gives both.
- R5: With `capMode` = 0, the counter taking a new value (by increment or clear) equal to register 0 pulses `irq0` for one cycle, in the cycle the new value appears. A new value equal to register 1 pulses `irq1` the same way. Each comparison uses the register value held before any write in that cycle.
- R6: With `capMode` = 1, a valid trigger edge copies the count from before the clear into register 1 and pulses `irq1`.
- R7: With `capMode` = 1, register 0 takes the current count and `irq0` pulses on one of two events, chosen by `cap0Sel`. With `cap0Sel` = 0, the event is a valid edge on `capPin`. With `cap0Sel` = 1, it is the trigger edge opposite to `trigEdge`: 01 pairs with falling, 10 pairs with rising, and 00 or 11 pair with none.
- R8: With `clkIsTrig` = 1, `countEn` has no effect. The counter only clears.
- R9: While `outEn` = 1, `toggleOut` inverts on every compare match with either register. When both registers match at once, it inverts only once.
- R10: `wrEn` writes `wrData` into register `wrSel`, where 0 selects register 0 and 1 selects register 1. A capture in the same cycle takes priority over the write. `rdData` shows register 0 for `rdSel` = 0, register 1 for 1, and the counter for 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode; 10 runs the clear-and-start mode |
| capMode | input | 1 | 0: both registers compare, 1: both registers capture |
| cap0Sel | input | 1 | Register 0 capture source: 0 second pin, 1 opposite trigger phase |
| trigEdge | input | 2 | Trigger pin edge select |
| capEdge | input | 2 | Second pin edge select |
| clkIsTrig | input | 1 | Illegal count-clock setting; suppresses counting |
| outEn | input | 1 | Enables the toggle output on matches |
| countEn | input | 1 | Count-clock enable |
| trigPin | input | 1 | Asynchronous trigger / clear pin |
| capPin | input | 1 | Asynchronous second capture pin |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Register selected for write |
| wrData | input | 16 | Write data |
| rdSel | input | 2 | Read select |
| rdData | output | 16 | Read data |
| irq0 | output | 1 | Interrupt pulse for register 0 |
| irq1 | output | 1 | Interrupt pulse for register 1 |
| toggleOut | output | 1 | Toggle output |

## Verification
The bench checks the trigger edge's timing against the three-cycle pin latency. A design off by one stage would clear the counter one cycle early or late, and every following count would miscompare. It drives long count-enable runs through the FFFFh rollover, where a saturating or stopping counter would freeze. It places trigger edges on cycles that also carry a count enable, so a design that let the increment win would show 0001h instead of 0000h. In capture mode it checks that register 1 holds the count from before the clear, and it exercises the opposite-phase source for register 0. A design that latched after the clear would read 0000h, and one with a wrong polarity pairing would miss captures or add extra ones.

// File: rtl/ect_pkg.sv
package ect_pkg;

  localparam logic [1:0] MODE_CLR_START = 2'b10;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edgeSel_e;

  typedef struct packed {
    logic run;
    logic cmp;
    logic clr;
    logic inc;
    logic cap0;
    logic cap1;
  } ctrlStrb_t;

  function automatic logic edgeHit(input logic [1:0] sel, input logic rise, input logic fall);
    case (sel)
      EDGE_RISE: edgeHit = rise;
      EDGE_FALL: edgeHit = fall;
      EDGE_BOTH: edgeHit = rise | fall;
      default:   edgeHit = 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] oppositeSel(input logic [1:0] sel);
    case (sel)
      EDGE_RISE: oppositeSel = EDGE_FALL;
      EDGE_FALL: oppositeSel = EDGE_RISE;
      default:   oppositeSel = EDGE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/ect_edge_det.sv
module ect_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic rise,
  output logic fall
);

  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[CHAIN_W-2:0], pinIn};
  end

  always_comb begin
    rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
    fall = ~chain[SYNC_STAGES-1] & chain[SYNC_STAGES];
  end

endmodule

// File: rtl/ect_ctrl.sv
module ect_ctrl
  import ect_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic [1:0] mode,
  input  logic      capMode,
  input  logic      cap0Sel,
  input  logic [1:0] trigEdge,
  input  logic [1:0] capEdge,
  input  logic      clkIsTrig,
  input  logic      countEn,
  input  logic      trigPin,
  input  logic      capPin,
  output ctrlStrb_t strb
);

  localparam int NUM_PINS = 2;

  logic [NUM_PINS-1:0] pinVec, riseVec, fallVec;

  assign pinVec = {capPin, trigPin};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    ect_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk  (clk),
      .rstN (rstN),
      .pinIn(pinVec[p]),
      .rise (riseVec[p]),
      .fall (fallVec[p])
    );
  end

  logic running, trigValid, trigOpp, capValid;

  always_comb begin
    running   = (mode == MODE_CLR_START);
    trigValid = edgeHit(trigEdge, riseVec[0], fallVec[0]);
    trigOpp   = edgeHit(oppositeSel(trigEdge), riseVec[0], fallVec[0]);
    capValid  = edgeHit(capEdge, riseVec[1], fallVec[1]);

    strb.run  = running;
    strb.cmp  = running & ~capMode;
    strb.clr  = running & trigValid;
    strb.inc  = running & countEn & ~clkIsTrig;
    strb.cap1 = running & capMode & trigValid;
    strb.cap0 = running & capMode & (cap0Sel ? trigOpp : capValid);
  end

endmodule

// File: rtl/ect_datapath.sv
module ect_datapath
  import ect_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic             outEn,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdSel,
  output logic [CNT_W-1:0] rdData,
  output logic             irq0,
  output logic             irq1,
  output logic             toggleOut
);

  localparam int NUM_REGS = 2;

  logic [CNT_W-1:0]    cnt, nxtCnt;
  logic [CNT_W-1:0]    ccReg [NUM_REGS];
  logic [NUM_REGS-1:0] capStrb, hit;
  logic                upd;

  always_comb begin
    upd     = strb.clr | strb.inc;
    nxtCnt  = strb.clr ? '0 : (strb.inc ? cnt + 1'b1 : cnt);
    capStrb = {strb.cap1, strb.cap0};
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    assign hit[i] = strb.cmp & upd & (nxtCnt == ccReg[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                ccReg[i] <= '0;
      else if (capStrb[i])                      ccReg[i] <= cnt;
      else if (wrEn && (wrSel == 1'(i)))        ccReg[i] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= '0;
      irq0      <= 1'b0;
      irq1      <= 1'b0;
      toggleOut <= 1'b0;
    end else if (!strb.run) begin
      cnt       <= '0;
      irq0      <= 1'b0;
      irq1      <= 1'b0;
      toggleOut <= 1'b0;
    end else begin
      cnt       <= nxtCnt;
      irq0      <= strb.cap0 | hit[0];
      irq1      <= strb.cap1 | hit[1];
      toggleOut <= toggleOut ^ (outEn & (|hit));
    end
  end

  always_comb begin
    case (rdSel)
      2'd0:    rdData = ccReg[0];
      2'd1:    rdData = ccReg[1];
      default: rdData = cnt;
    endcase
  end

  // R2: an increment without a clear advances the count by exactly one
  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && strb.inc && !strb.clr) |=> (cnt == $past(cnt) + 1'b1));

  // R3: a clear strobe leaves zero regardless of the count enable
  a_r3_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && strb.clr) |=> (cnt == '0));

  // R1: a stopped mode holds everything quiet
  a_r1_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> (cnt == '0 && !irq0 && !irq1 && !toggleOut));

  // R6: a trigger capture stores the pre-clear count and pulses irq1
  a_r6_cap1: assert property (@(posedge clk) disable iff (!rstN)
    strb.cap1 |=> (ccReg[1] == $past(cnt) && irq1));

  // R7: a register-0 capture stores the count and pulses irq0
  a_r7_cap0: assert property (@(posedge clk) disable iff (!rstN)
    strb.cap0 |=> (ccReg[0] == $past(cnt) && irq0));

endmodule

// File: rtl/edge_clear_timer.sv
module edge_clear_timer
  import ect_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic             capMode,
  input  logic             cap0Sel,
  input  logic [1:0]       trigEdge,
  input  logic [1:0]       capEdge,
  input  logic             clkIsTrig,
  input  logic             outEn,
  input  logic             countEn,
  input  logic             trigPin,
  input  logic             capPin,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdSel,
  output logic [CNT_W-1:0] rdData,
  output logic             irq0,
  output logic             irq1,
  output logic             toggleOut
);

  ctrlStrb_t strb;

  ect_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .mode     (mode),
    .capMode  (capMode),
    .cap0Sel  (cap0Sel),
    .trigEdge (trigEdge),
    .capEdge  (capEdge),
    .clkIsTrig(clkIsTrig),
    .countEn  (countEn),
    .trigPin  (trigPin),
    .capPin   (capPin),
    .strb     (strb)
  );

  ect_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .outEn    (outEn),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .rdSel    (rdSel),
    .rdData   (rdData),
    .irq0     (irq0),
    .irq1     (irq1),
    .toggleOut(toggleOut)
  );

endmodule

// File: tb/edge_clear_timer_bench.sv
module edge_clear_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 190000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        capMode = 1'b0, cap0Sel = 1'b0, clkIsTrig = 1'b0, outEn = 1'b0;
  logic [1:0]  trigEdge = 2'b01, capEdge = 2'b01;
  logic        countEn = 1'b0, trigPin = 1'b0, capPin = 1'b0;
  logic        wrEn = 1'b0, wrSel = 1'b0;
  logic [15:0] wrData = 16'h0;
  logic [1:0]  rdSel = 2'd2;
  logic [15:0] rdData;
  logic        irq0, irq1, toggleOut;

  edge_clear_timer u_edge_clear_timer (
    .clk(clk), .rstN(rstN), .mode(mode), .capMode(capMode), .cap0Sel(cap0Sel),
    .trigEdge(trigEdge), .capEdge(capEdge), .clkIsTrig(clkIsTrig), .outEn(outEn),
    .countEn(countEn), .trigPin(trigPin), .capPin(capPin), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .rdSel(rdSel), .rdData(rdData),
    .irq0(irq0), .irq1(irq1), .toggleOut(toggleOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    nVec = 0, nBad = 0, cycles = 0;
  string curReq = "R1";
  bit    compareOn = 1'b0;
  bit    done = 1'b0;

  // behavioural reference state
  int mCnt = 0, mR0 = 0, mR1 = 0;
  bit mIrq0 = 0, mIrq1 = 0, mTog = 0;
  bit tq[$];
  bit cq[$];

  function automatic bit selHit(int sel, bit r, bit f);
    if (sel == 1) return r;
    if (sel == 2) return f;
    if (sel == 3) return r | f;
    return 0;
  endfunction

  function automatic int oppSel(int sel);
    if (sel == 1) return 2;
    if (sel == 2) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mR0 = 0; mR1 = 0; mIrq0 = 0; mIrq1 = 0; mTog = 0;
      tq = '{0, 0, 0};
      cq = '{0, 0, 0};
    end else begin
      // queue holds {newest ... oldest}: index 1 = second stage, index 2 = previous
      bit tR, tF, cR, cF, trigV, trigO, capV, clr, inc, upd, c0, c1, m0, m1;
      int nxt, oldCnt;
      tR = tq[1] && !tq[2];  tF = !tq[1] && tq[2];
      cR = cq[1] && !cq[2];  cF = !cq[1] && cq[2];
      trigV = selHit(trigEdge, tR, tF);
      trigO = selHit(oppSel(trigEdge), tR, tF);
      capV  = selHit(capEdge, cR, cF);
      oldCnt = mCnt;
      if (mode != 2'b10) begin
        mCnt = 0; mIrq0 = 0; mIrq1 = 0; mTog = 0;
        c0 = 0; c1 = 0;
      end else begin
        clr = trigV;
        inc = countEn && !clkIsTrig;
        upd = clr || inc;
        nxt = clr ? 0 : (inc ? (mCnt + 1) % 65536 : mCnt);
        c1 = capMode && trigV;
        c0 = capMode && (cap0Sel ? trigO : capV);
        m0 = !capMode && upd && (nxt == mR0);
        m1 = !capMode && upd && (nxt == mR1);
        mIrq0 = c0 || m0;
        mIrq1 = c1 || m1;
        if (outEn && (m0 || m1)) mTog = !mTog;
        mCnt = nxt;
      end
      if (c0) mR0 = oldCnt; else if (wrEn && !wrSel) mR0 = wrData;
      if (c1) mR1 = oldCnt; else if (wrEn && wrSel) mR1 = wrData;
      tq.push_front(trigPin); void'(tq.pop_back());
      cq.push_front(capPin);  void'(cq.pop_back());
    end
  end

  task automatic checkVal(string what, int act, int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", curReq, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    #1;
    if (compareOn && rstN) begin
      int expRd;
      expRd = (rdSel == 0) ? mR0 : (rdSel == 1) ? mR1 : mCnt;
      checkVal("rdData", int'(rdData), expRd);
      checkVal("irq0", int'(irq0), int'(mIrq0));
      checkVal("irq1", int'(irq1), int'(mIrq1));
      checkVal("toggleOut", int'(toggleOut), int'(mTog));
    end
  end

  int lfsr = 32'h1ACE5;
  function automatic int nextRand();
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h80200003 : 0);
    return lfsr;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic randCycles(int n, bit randEn, bit randWr, bit randPins);
    for (int i = 0; i < n; i++) begin
      int r;
      @(negedge clk);
      r = nextRand();
      if (randEn)   countEn = r[0] | r[1];
      rdSel = r[3:2];
      if (randWr) begin
        wrEn = (r[7:4] == 4'h0);
        wrSel = r[8];
        wrData = r[24:9];
      end else wrEn = 1'b0;
      if (randPins) begin
        if (r[13:10] == 4'h3) trigPin = ~trigPin;
        if (r[17:14] == 4'h5) capPin = ~capPin;
      end
    end
    wrEn = 1'b0;
  endtask

  task automatic writeReg(bit sel, logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    tq = '{0, 0, 0};
    cq = '{0, 0, 0};
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1: reset state
    curReq = "R1";
    rdSel = 2'd2; #2;
    checkVal("reset count", int'(rdData), 0);
    checkVal("reset irq0", int'(irq0), 0);
    checkVal("reset toggleOut", int'(toggleOut), 0);
    compareOn = 1'b1;

    // R1: stopped modes ignore count enables and pin edges
    mode = 2'b01;
    randCycles(30, 1, 0, 1);
    mode = 2'b11;
    randCycles(20, 1, 0, 1);

    // R10: register writes and read select
    curReq = "R10";
    writeReg(0, 16'h0010);
    writeReg(1, 16'h0025);
    rdSel = 2'd0; tick(2);
    rdSel = 2'd1; tick(2);

    // R2 R5 R9: compare mode with irregular enables, toggle enabled
    curReq = "R5";
    mode = 2'b10; capMode = 1'b0; outEn = 1'b1;
    randCycles(150, 1, 0, 0);
    curReq = "R9";
    writeReg(1, 16'h0010);
    randCycles(120, 1, 0, 0);
    outEn = 1'b0;
    randCycles(60, 1, 0, 0);
    outEn = 1'b1;

    // R3 R4: trigger edges under every polarity select
    for (int s = 0; s < 4; s++) begin
      curReq = (s == 0) ? "R4" : "R3";
      trigEdge = s[1:0];
      randCycles(250, 1, 0, 1);
    end
    curReq = "R3";
    trigEdge = 2'b11; countEn = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); trigPin = ~trigPin;
      tick(4 + k);
    end

    // R2: rollover from FFFFh to 0000h
    curReq = "R2";
    trigEdge = 2'b00;
    writeReg(0, 16'hFFFF);
    writeReg(1, 16'h0000);
    countEn = 1'b1; rdSel = 2'd2;
    tick(65560);

    // R6: capture into register 1 on trigger edges, with stray writes
    curReq = "R6";
    capMode = 1'b1; trigEdge = 2'b01; cap0Sel = 1'b0; capEdge = 2'b00;
    randCycles(400, 1, 1, 1);

    // R7: register 0 capture from second pin, then from opposite trigger phase
    curReq = "R7";
    capEdge = 2'b10;
    randCycles(400, 1, 1, 1);
    cap0Sel = 1'b1;
    trigEdge = 2'b10;
    randCycles(300, 1, 1, 1);
    trigEdge = 2'b11;
    randCycles(200, 1, 1, 1);

    // R10: capture priority against writes, dense writes
    curReq = "R10";
    trigEdge = 2'b01; cap0Sel = 1'b0; capEdge = 2'b11;
    randCycles(400, 1, 1, 1);

    // R8: count clock tied to trigger edge suppresses counting
    curReq = "R8";
    clkIsTrig = 1'b1; capMode = 1'b0;
    randCycles(300, 1, 0, 1);
    clkIsTrig = 1'b0;
    randCycles(100, 1, 0, 1);

    // R1: leaving the mode resets counter and toggle
    curReq = "R1";
    mode = 2'b00;
    randCycles(30, 1, 0, 1);

    done = 1'b1;
  end

  initial begin
    wait (done || cycles > MAX_CYCLES);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule